// File: doc/BRIEF.md
# Qualified Programmable Event Counter

This block is one programmable event counter. Each cycle the core presents a set of small per-lane occurrence counts, arranged as a number of event groups with one lane per sub-event. Software picks a group with an 8-bit event code and picks lanes inside it with an 8-bit lane mask. The counts of the selected lanes are summed. A qualifier stage then decides what is added to the counter. It can add the raw sum. It can instead add one per cycle whose sum passes a threshold compare, which may be inverted. It can add one only when that condition turns on. All of this is gated by the current privilege level and by a global enable.

Software reaches the block through a small register port with two addresses: a control word and the 48-bit counter itself. When the counter wraps, a sticky overflow flag is set. The flag drives the interrupt output if interrupts are enabled. Any register write clears the flag.

Top module: `evc_top`

## Requirements
- R1: The event code selects group `code` when `code < NUM_GRP`. Each set lane-mask bit i adds lane i of that group to the per-cycle sum. A code of NUM_GRP or higher yields a sum of zero.
- R2: With threshold 0, the per-cycle sum is added to the counter as is, and the invert and edge bits have no effect.
- R3: With a nonzero threshold and invert clear, the counter adds exactly one in each cycle whose sum is greater than or equal to the threshold, and nothing otherwise.
- R4: With a nonzero threshold and invert set, the counter adds one in each cycle whose sum is below the threshold. With threshold 1 this counts cycles that have zero events.
- R5: With a nonzero threshold and edge set, the counter adds one only in a cycle where the qualified condition is true and was false in the previous counted cycle.
- R6: The os bit enables counting at privilege 0. The usr bit enables counting at privileges 1 to 3. With both bits clear, every privilege counts.
- R7: While the enable bit is clear, the counter does not change except through a write.
- R8: A carry out of bit 47 wraps the counter and sets a sticky overflow flag. `irq` equals that flag ANDed with the interrupt-enable bit.
- R9: A write to address 1 loads the counter. A write to address 0 loads the control word and clears the edge history. Any write clears the overflow flag. No events are counted in a write cycle.
- R10: Reading address 0 returns the control word: code [7:0], lane mask [15:8], threshold [23:16], invert 24, edge 25, os 26, usr 27, interrupt enable 28, enable 29, overflow 31. Reading address 1 returns the counter. Reads are combinational.
- R11: After reset, the counter, the control word, the overflow flag and `irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_lanes | input | NUM_GRP*LANES*LANE_W | Per-cycle counts; group g lane i at bits (g*LANES+i)*LANE_W |
| priv | input | 2 | Current privilege level, 0 is most privileged |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control, 1 = counter |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 1 | 0 = control/status, 1 = counter |
| rd_data | output | CNT_W | Read data, combinational |
| irq | output | 1 | Overflow interrupt |

## Verification
Event inputs and writes that are presented in a cycle show up in the counter, the overflow flag and `irq` after exactly one rising edge, because no pipeline register sits between the lane inputs and the counter. The bench drives each cycle's inputs just after a falling edge and steps its reference model once for that cycle. It then compares `rd_data` and `irq` at the next falling edge. A read of the control word needs no edge, so it is compared in the same half-cycle in which `rd_addr` changes.

// File: rtl/evc_pkg.sv
package evc_pkg;
   localparam int CTRL_W = 30;

   // Control word; field order sets the software-visible bit positions.
   typedef struct packed {
      logic       en;
      logic       irq_en;
      logic       usr;
      logic       os;
      logic       edge_det;
      logic       inv;
      logic [7:0] thr;
      logic [7:0] umask;
      logic [7:0] code;
   } evc_ctrl_t;

   localparam int OVF_BIT = 31;
endpackage

// File: rtl/evc_select.sv
module evc_select #(
   parameter int NUM_GRP = 4,
   parameter int LANES   = 8,
   parameter int LANE_W  = 3,
   parameter int SUM_W   = 6
) (
   input  logic [NUM_GRP*LANES*LANE_W-1:0] lanes_i,
   input  logic [7:0]                      code_i,
   input  logic [7:0]                      umask_i,
   output logic [SUM_W-1:0]                sum_o
);
   logic [LANE_W-1:0] lane_a [NUM_GRP][LANES];

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         assign lane_a[g][i] = lanes_i[(g*LANES+i)*LANE_W +: LANE_W];
      end
   end

   always_comb begin
      sum_o = '0;
      for (int g = 0; g < NUM_GRP; g++) begin
         for (int i = 0; i < LANES; i++) begin
            if (code_i == 8'(g) && umask_i[i])
               sum_o = sum_o + SUM_W'(lane_a[g][i]);
         end
      end
   end
endmodule

// File: rtl/evc_qual.sv
module evc_qual
   import evc_pkg::*;
#(
   parameter int SUM_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  evc_ctrl_t        ctrl_i,
   input  logic [1:0]       priv_i,
   input  logic             wr_any_i,
   input  logic             clr_hist_i,
   input  logic [SUM_W-1:0] sum_i,
   output logic [SUM_W-1:0] inc_o
);
   localparam int CMP_W = (SUM_W > 8) ? SUM_W : 8;

   logic             priv_ok, active, cmp_hit, cond, prev_q;
   logic [CMP_W-1:0] sum_x, thr_x;

   assign sum_x = CMP_W'(sum_i);
   assign thr_x = CMP_W'(ctrl_i.thr);

   always_comb begin
      if (!ctrl_i.os && !ctrl_i.usr) priv_ok = 1'b1;
      else if (priv_i == 2'd0)       priv_ok = ctrl_i.os;
      else                           priv_ok = ctrl_i.usr;
   end

   assign active  = ctrl_i.en && priv_ok && !wr_any_i;
   assign cmp_hit = ctrl_i.inv ? (sum_x < thr_x) : (sum_x >= thr_x);
   assign cond    = active && cmp_hit;

   always_comb begin
      if (ctrl_i.thr == 8'd0)    inc_o = active ? sum_i : '0;
      else if (ctrl_i.edge_det)  inc_o = SUM_W'(cond && !prev_q);
      else                       inc_o = SUM_W'(cond);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr_hist_i) prev_q <= 1'b0;
      else if (!wr_any_i)       prev_q <= cond;
   end
endmodule

// File: rtl/evc_accum.sv
module evc_accum #(
   parameter int CNT_W = 48,
   parameter int SUM_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SUM_W-1:0] inc_i,
   input  logic             wr_any_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             ovf_o
);
   logic [CNT_W:0] nxt;

   assign nxt = {1'b0, cnt_o} + (CNT_W+1)'(inc_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_o <= '0;
         ovf_o <= 1'b0;
      end else if (wr_any_i) begin
         if (load_i) cnt_o <= load_val_i;
         ovf_o <= 1'b0;
      end else begin
         cnt_o <= nxt[CNT_W-1:0];
         if (nxt[CNT_W]) ovf_o <= 1'b1;
      end
   end
endmodule

// File: rtl/evc_top.sv
module evc_top
   import evc_pkg::*;
#(
   parameter int NUM_GRP = 4,
   parameter int LANES   = 8,
   parameter int LANE_W  = 3,
   parameter int CNT_W   = 48
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [NUM_GRP*LANES*LANE_W-1:0]  ev_lanes,
   input  logic [1:0]                       priv,
   input  logic                             wr_en,
   input  logic                             wr_addr,
   input  logic [CNT_W-1:0]                 wr_data,
   input  logic                             rd_addr,
   output logic [CNT_W-1:0]                 rd_data,
   output logic                             irq
);
   localparam int MAX_SUM = LANES * ((1 << LANE_W) - 1);
   localparam int SUM_W   = $clog2(MAX_SUM + 1);

   if (LANES < 1 || LANES > 8) begin : g_bad_lanes
      $error("evc_top: LANES must be 1..8");
   end
   if (NUM_GRP < 1 || NUM_GRP > 256) begin : g_bad_grp
      $error("evc_top: NUM_GRP must be 1..256");
   end
   if (CNT_W < 32) begin : g_bad_cnt
      $error("evc_top: CNT_W must hold the 32-bit control view");
   end

   evc_ctrl_t        ctrl_q;
   logic [SUM_W-1:0] sum, inc;
   logic [CNT_W-1:0] cnt_q;
   logic             ovf_q, ctrl_wr;

   assign ctrl_wr = wr_en && !wr_addr;

   always_ff @(posedge clk) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (ctrl_wr) ctrl_q <= wr_data[CTRL_W-1:0];
   end

   evc_select #(.NUM_GRP(NUM_GRP), .LANES(LANES), .LANE_W(LANE_W), .SUM_W(SUM_W)) u_sel (
      .lanes_i (ev_lanes),
      .code_i  (ctrl_q.code),
      .umask_i (ctrl_q.umask),
      .sum_o   (sum)
   );

   evc_qual #(.SUM_W(SUM_W)) u_qual (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctrl_i     (ctrl_q),
      .priv_i     (priv),
      .wr_any_i   (wr_en),
      .clr_hist_i (ctrl_wr),
      .sum_i      (sum),
      .inc_o      (inc)
   );

   evc_accum #(.CNT_W(CNT_W), .SUM_W(SUM_W)) u_acc (
      .clk        (clk),
      .rst_n      (rst_n),
      .inc_i      (inc),
      .wr_any_i   (wr_en),
      .load_i     (wr_en && wr_addr),
      .load_val_i (wr_data),
      .cnt_o      (cnt_q),
      .ovf_o      (ovf_q)
   );

   assign rd_data = rd_addr ? cnt_q : CNT_W'({ovf_q, 1'b0, ctrl_q});
   assign irq     = ovf_q && ctrl_q.irq_en;
endmodule

// File: rtl/evc_top_chk.sv
module evc_top_chk
   import evc_pkg::*;
#(
   parameter int CNT_W = 48
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             wr_addr,
   input logic [CNT_W-1:0] wr_data,
   input logic [1:0]       priv,
   input evc_ctrl_t        ctrl_q,
   input logic [CNT_W-1:0] cnt_q,
   input logic             ovf_q,
   input logic             irq
);
   // R9: counter write loads the written value
   a_r9_cnt_load: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr) |=> cnt_q == $past(wr_data));
   // R9: control write leaves the counter alone
   a_r9_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_addr) |=> $stable(cnt_q));
   // R9: any write clears overflow
   a_r9_ovf_clear: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !ovf_q);
   // R7: disabled counter holds
   a_r7_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q.en && !wr_en) |=> $stable(cnt_q));
   // R8: overflow is sticky until a write
   a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !wr_en) |=> ovf_q);
   // R8: interrupt only with overflow and enable
   a_r8_irq_src: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ovf_q && ctrl_q.irq_en));
   // R3: thresholded counting steps by at most one
   a_r3_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.thr != 8'd0 && !wr_en) |=> (cnt_q - $past(cnt_q)) <= CNT_W'(1));
   // R6: os-only mode ignores user privilege
   a_r6_user_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.os && !ctrl_q.usr && priv != 2'd0 && !wr_en) |=> $stable(cnt_q));
endmodule

bind evc_top evc_top_chk #(.CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .wr_data (wr_data),
   .priv    (priv),
   .ctrl_q  (ctrl_q),
   .cnt_q   (cnt_q),
   .ovf_q   (ovf_q),
   .irq     (irq)
);

// File: tb/evc_top_tb.sv
module evc_top_tb;
   localparam int CLK_P   = 10;
   localparam int NG      = 4;
   localparam int NL      = 8;
   localparam int LW      = 3;
   localparam int CW      = 48;
   localparam longint unsigned CMASK = (64'd1 << CW) - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NG*NL*LW-1:0] ev_lanes = '0;
   logic [1:0]        priv = 2'd0;
   logic              wr_en = 1'b0;
   logic              wr_addr = 1'b0;
   logic [CW-1:0]     wr_data = '0;
   logic              rd_addr = 1'b1;
   logic [CW-1:0]     rd_data;
   logic              irq;

   int n_chk = 0;
   int n_err = 0;
   int lane_v [NG][NL];
   string cur_req = "R11";

   // reference state
   longint unsigned m_cnt = 0;
   longint unsigned m_ctrl = 0;
   bit m_ovf = 0;
   bit m_prev = 0;

   always #(CLK_P/2) clk = ~clk;

   evc_top #(.NUM_GRP(NG), .LANES(NL), .LANE_W(LW), .CNT_W(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .ev_lanes(ev_lanes), .priv(priv),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 20000) begin
         n_err++;
         $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 20000)", wd);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
         $finish;
      end
   end

   function automatic longint unsigned mk(int code, int um, int thr, bit inv, bit edg,
                                          bit os, bit usr, bit ie, bit en);
      return longint'(code) | (longint'(um) << 8) | (longint'(thr) << 16) |
             (longint'(inv) << 24) | (longint'(edg) << 25) | (longint'(os) << 26) |
             (longint'(usr) << 27) | (longint'(ie) << 28) | (longint'(en) << 29);
   endfunction

   task automatic pack_lanes();
      for (int g = 0; g < NG; g++)
         for (int i = 0; i < NL; i++)
            ev_lanes[(g*NL+i)*LW +: LW] = LW'(lane_v[g][i]);
   endtask

   task automatic set_all(int v);
      for (int g = 0; g < NG; g++)
         for (int i = 0; i < NL; i++) lane_v[g][i] = v;
      pack_lanes();
   endtask

   function automatic void model_step();
      int code, um, thr, sum;
      bit inv, edg, os, usr, en, pok, active, cond;
      longint unsigned inc;
      if (wr_en) begin
         if (wr_addr) m_cnt = longint'(wr_data) & CMASK;
         else begin m_ctrl = longint'(wr_data) & 64'h3FFF_FFFF; m_prev = 0; end
         m_ovf = 0;
         return;
      end
      code = int'(m_ctrl & 8'hFF);      um = int'((m_ctrl >> 8) & 8'hFF);
      thr  = int'((m_ctrl >> 16) & 8'hFF);
      inv = m_ctrl[24]; edg = m_ctrl[25]; os = m_ctrl[26]; usr = m_ctrl[27]; en = m_ctrl[29];
      sum = 0;
      if (code < NG)
         for (int i = 0; i < NL; i++) if (um[i]) sum += lane_v[code][i];
      pok = (!os && !usr) || (priv == 0 ? os : usr);
      active = en && pok;
      if (thr == 0) inc = active ? longint'(sum) : 0;
      else begin
         cond = active && (inv ? (sum < thr) : (sum >= thr));
         inc = edg ? longint'(cond && !m_prev) : longint'(cond);
         m_prev = cond;
      end
      m_cnt = m_cnt + inc;
      if (m_cnt > CMASK) begin m_cnt = m_cnt & CMASK; m_ovf = 1; end
   endfunction

   task automatic check(longint unsigned act, longint unsigned exp, string what);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
      end
   endtask

   task automatic compare();
      longint unsigned exp_rd;
      exp_rd = rd_addr ? m_cnt : (m_ctrl | (longint'(m_ovf) << 31));
      check(longint'(rd_data), exp_rd, rd_addr ? "counter" : "control");
      check(longint'(irq), longint'(m_ovf && m_ctrl[28]), "irq");
   endtask

   // one clock with current inputs; inputs were set after a falling edge
   task automatic tick(int n = 1);
      for (int k = 0; k < n; k++) begin
         model_step();
         @(posedge clk);
         @(negedge clk);
         wr_en = 1'b0;
         compare();
      end
   endtask

   task automatic wr(bit a, longint unsigned d);
      wr_en = 1'b1; wr_addr = a; wr_data = CW'(d);
      tick();
   endtask

   task automatic read_ctrl();
      rd_addr = 1'b0; #1; compare(); rd_addr = 1'b1; #1;
   endtask

   initial begin
      set_all(0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cur_req = "R11"; compare(); read_ctrl();

      // R1, R2: combined lanes summed, group select
      cur_req = "R1";
      lane_v[2][0] = 3; lane_v[2][3] = 5; lane_v[2][7] = 7; lane_v[1][0] = 6; pack_lanes();
      wr(0, mk(2, 8'h89, 0, 1, 1, 0, 0, 0, 1));
      tick(4);
      check(longint'(rd_data), 60, "R1 sum of three lanes x4 (expect 15/cycle)");
      cur_req = "R2"; read_ctrl();
      wr(0, mk(1, 8'h01, 0, 0, 0, 0, 0, 0, 1)); tick(2);
      cur_req = "R1";
      wr(0, mk(5, 8'hFF, 0, 0, 0, 0, 0, 0, 1)); tick(3);   // code out of range
      check(longint'(rd_data), 72, "R1 out-of-range code adds nothing");

      // R3: threshold compare
      cur_req = "R3";
      wr(1, 0);
      wr(0, mk(0, 8'h03, 3, 0, 0, 0, 0, 0, 1));
      for (int s = 0; s < 6; s++) begin
         lane_v[0][0] = s; lane_v[0][1] = (s > 2) ? 1 : 0; pack_lanes(); tick();
      end

      // R4: inverted compare, stall counting
      cur_req = "R4";
      wr(1, 0);
      wr(0, mk(0, 8'h03, 1, 1, 0, 0, 0, 0, 1));
      for (int s = 0; s < 6; s++) begin
         lane_v[0][0] = (s % 3 == 0) ? 2 : 0; lane_v[0][1] = 0; pack_lanes(); tick();
      end
      check(longint'(rd_data), 4, "R4 zero-event cycles");
      wr(0, mk(0, 8'h03, 4, 1, 0, 0, 0, 0, 1));
      lane_v[0][0] = 3; pack_lanes(); tick(2);
      lane_v[0][0] = 5; pack_lanes(); tick(2);

      // R5: edge
      cur_req = "R5";
      wr(1, 0);
      wr(0, mk(0, 8'h01, 2, 0, 1, 0, 0, 0, 1));
      lane_v[0][0] = 3; pack_lanes(); tick(4);
      lane_v[0][0] = 0; pack_lanes(); tick(2);
      lane_v[0][0] = 2; pack_lanes(); tick(3);
      check(longint'(rd_data), 2, "R5 two rising conditions");
      // R9: control rewrite clears edge history while condition stays true
      cur_req = "R9";
      wr(0, mk(0, 8'h01, 2, 0, 1, 0, 0, 0, 1)); tick(2);
      check(longint'(rd_data), 3, "R9 history cleared by control write");
      wr(1, 100); tick(1);
      check(longint'(rd_data), 100, "R9 counter write, no recount after it");

      // R6: privilege gating
      cur_req = "R6";
      wr(1, 0);
      lane_v[0][0] = 1; pack_lanes();
      wr(0, mk(0, 8'h01, 0, 0, 0, 1, 0, 0, 1));
      for (int p = 0; p < 4; p++) begin priv = 2'(p); tick(2); end
      wr(0, mk(0, 8'h01, 0, 0, 0, 0, 1, 0, 1));
      for (int p = 0; p < 4; p++) begin priv = 2'(p); tick(2); end
      wr(0, mk(0, 8'h01, 0, 0, 0, 0, 0, 0, 1));
      for (int p = 0; p < 4; p++) begin priv = 2'(p); tick(1); end
      check(longint'(rd_data), 12, "R6 os 2 + usr 6 + both 4");
      priv = 2'd0;

      // R7: global enable
      cur_req = "R7";
      wr(0, mk(0, 8'h01, 0, 0, 0, 0, 0, 0, 0)); tick(5);
      check(longint'(rd_data), 12, "R7 disabled holds");

      // R8: wrap, sticky overflow, interrupt
      cur_req = "R8";
      lane_v[0][0] = 5; pack_lanes();
      wr(1, CMASK - 2);
      wr(0, mk(0, 8'h01, 0, 0, 0, 0, 0, 1, 1));
      tick(1);
      check(longint'(rd_data), 2, "R8 wrapped value");
      check(longint'(irq), 1, "R8 irq raised");
      tick(2); read_ctrl();
      wr(0, mk(0, 8'h01, 0, 0, 0, 0, 0, 0, 1));
      wr(1, CMASK);
      tick(1);
      check(longint'(irq), 0, "R8 irq masked when disabled");
      cur_req = "R10"; read_ctrl();
      cur_req = "R9";
      wr(1, 7);
      check(longint'(irq), 0, "R9 write cleared overflow");
      read_ctrl();

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule